// File: doc/BRIEF.md
# Sized Little-Endian Memory Port

This block is a byte-addressed data store with one request port. Each request
carries a byte start address, a two-bit size code, a read/write flag and up to
64 bits of write data. One, two, four or eight bytes are moved per access. The
lowest-order byte of a value always sits at the start address, and each higher
byte sits at the next address up.

Internally the storage is split into eight byte lanes, one for each byte offset
inside an 8-byte row. A write is steered onto the lanes it covers. A read fetches
a whole row and shifts the addressed bytes down to bit 0. Every access must be
naturally aligned. A request that breaks this rule is not split into two
accesses. It is refused instead: it writes nothing, it returns zero data, and it
raises an error pulse. Read results appear one clock after the request, with a
strobe. The storage depth is set by the address width parameter.

Top module: `sized_le_mem`

## Requirements
- R1: Once reset is released, and before any request is made, `rsp_valid` and `rsp_err` are low and `rsp_rdata` is zero.
- R2: `req_size` selects the access width: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 is 4 bytes and 2'b11 is 8 bytes. A read returns exactly that many bytes.
- R3: Byte order is little-endian. Bits [8k+7:8k] of the data belong to address A+k. After a 4-byte write of 0x12345678 at A, the byte at A reads 0x78, the byte at A+3 reads 0x12 and the 2-byte read at A+2 gives 0x1234.
- R4: A write changes only the bytes it covers. Every other byte keeps its value, including the other bytes of the same 8-byte row.
- R5: An access is aligned when its address is a multiple of its byte count. A misaligned request makes `rsp_err` high for exactly one cycle, in the cycle after the request. It changes no stored byte.
- R6: A misaligned read still gives `rsp_valid` in the next cycle, and its `rsp_rdata` is zero.
- R7: Read data is right-justified. All bits above the access width are zero.
- R8: `rsp_valid` is high exactly in the cycle after a read request. Writes and idle cycles produce no `rsp_valid`, and `rsp_rdata` is zero whenever `rsp_valid` is low.
- R9: Every address from 0 up to 2^ADDR_W-1 holds its own byte, the top address included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the response path |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (see R2) |
| req_addr | input | ADDR_W | Byte start address |
| req_wdata | input | 64 | Write value, right-justified |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read request |
| rsp_err | output | 1 | One-cycle pulse for a misaligned request |
| rsp_rdata | output | 64 | Read value, right-justified and zero-padded |

## Verification
The store is first filled row by row with distinct 8-byte patterns. After that,
any byte taken from the wrong lane or the wrong row shows up as a wrong value.
A single 4-byte value is then read back with narrower reads at each offset. This
separates a little-endian lane order from a reversed one, and it shows whether
the shift amount is right. Narrow writes into rows that already hold data, each
followed by a full 8-byte read, show whether neighbouring bytes were left alone.
Misaligned writes at every size, each checked by an aligned read of the same
row, together with misaligned reads and a long pseudo-random mix of sizes and
offsets, confirm that the alignment rule and the zero padding apply to all four
sizes and not only to the widest one.

// File: rtl/sized_le_mem.sv
module sized_le_mem #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata
);
  localparam int LANES = 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int ROW_W = ADDR_W - LANE_W;
  localparam int ROWS = 1 << ROW_W;

  logic [ROW_W-1:0]  row;
  logic [LANE_W-1:0] lane;
  logic              misal;
  logic [LANES-1:0]  span, lane_en;
  logic [63:0]       wdata_sh;
  logic              wr_en, rd_en;

  assign row  = req_addr[ADDR_W-1:LANE_W];
  assign lane = req_addr[LANE_W-1:0];

  always_comb begin
    unique case (req_size)
      2'b00: begin span = 8'h01; misal = 1'b0; end
      2'b01: begin span = 8'h03; misal = lane[0]; end
      2'b10: begin span = 8'h0F; misal = |lane[1:0]; end
      default: begin span = 8'hFF; misal = |lane; end
    endcase
  end

  assign lane_en  = span << lane;
  assign wdata_sh = req_wdata << {lane, 3'b000};
  assign wr_en    = req_valid & req_write & ~misal;
  assign rd_en    = req_valid & ~req_write & ~misal;

  logic [63:0] row_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bank [ROWS];
    logic [7:0] rd_byte;
    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) bank[row] <= wdata_sh[8*g +: 8];
      if (rd_en) rd_byte <= bank[row];
    end
    assign row_q[8*g +: 8] = rd_byte;
  end

  logic              valid_q, err_q;
  logic [1:0]        size_q;
  logic [LANE_W-1:0] lane_q;
  logic [63:0]       keep_mask, shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= 2'b00;
      lane_q  <= '0;
    end else begin
      valid_q <= req_valid & ~req_write;
      err_q   <= req_valid & misal;
      if (req_valid) begin
        size_q <= req_size;
        lane_q <= lane;
      end
    end
  end

  always_comb begin
    unique case (size_q)
      2'b00:   keep_mask = 64'h0000_0000_0000_00FF;
      2'b01:   keep_mask = 64'h0000_0000_0000_FFFF;
      2'b10:   keep_mask = 64'h0000_0000_FFFF_FFFF;
      default: keep_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  end

  assign shifted   = row_q >> {lane_q, 3'b000};
  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = (valid_q && !err_q) ? (shifted & keep_mask) : 64'd0;

  p_err_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid));

  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> !rsp_err || $past(req_valid));

  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_misaligned_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == 64'd0);

  p_pad_above_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_size) != 2'b11) |->
      (rsp_rdata >> (8 << $past(req_size))) == 64'd0);

  p_idle_data_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_rdata == 64'd0);
endmodule

// File: tb/tb_sized_le_mem.sv
module tb_sized_le_mem;
  localparam int AW = 10;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [63:0]   rsp_rdata;

  always #2.5 clk = ~clk;

  sized_le_mem #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  typedef struct {
    logic        v;
    logic        e;
    logic [63:0] d;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  model [NB];
  int          checks = 0, errors = 0;
  bit          mon_on = 0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic drive(input bit v, input bit w, input logic [1:0] sz,
                       input int a, input logic [63:0] wd, input string tag);
    exp_t x;
    int   n;
    bit   mis;
    @(negedge clk);
    req_valid = v; req_write = w; req_size = sz;
    req_addr = AW'(a); req_wdata = wd;
    n   = 1 << sz;
    mis = v && ((a % n) != 0);
    x.v = v && !w;
    x.e = mis;
    x.d = '0;
    x.tag = tag;
    if (v && !mis) begin
      for (int k = 0; k < n; k++) begin
        if (w) model[a + k] = wd[8*k +: 8];
        else   x.d[8*k +: 8] = model[a + k];
      end
    end
    sb.push_back(x);
  endtask

  task automatic rd(input logic [1:0] sz, input int a, input string tag);
    drive(1'b1, 1'b0, sz, a, 64'd0, tag);
  endtask

  task automatic wr(input logic [1:0] sz, input int a, input logic [63:0] d, input string tag);
    drive(1'b1, 1'b1, sz, a, d, tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 2'b00, 0, 64'd0, tag);
  endtask

  // monitor: compares every cycle's response against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (rsp_valid !== x.v || rsp_err !== x.e || rsp_rdata !== x.d) begin
          errors++;
          $display("FAIL %s: got v=%b e=%b d=%h expected v=%b e=%b d=%h",
                   x.tag, rsp_valid, rsp_err, rsp_rdata, x.v, x.e, x.d);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== 64'd0) begin
      errors++;
      $display("FAIL R1: got v=%b e=%b d=%h expected v=0 e=0 d=0", rsp_valid, rsp_err, rsp_rdata);
    end
    mon_on = 1;

    // R2 / R9: fill every row with a distinct quadword
    for (int r = 0; r < NB / 8; r++)
      wr(2'b11, 8 * r, {8'(r), 8'hA5, 8'(r ^ 8'h3C), 8'h96, 8'(r + 1), 8'h5A, 8'(~r), 8'hC3}, "R2 fill");
    for (int r = 0; r < NB / 8; r += 17) rd(2'b11, 8 * r, "R2 quad read");
    rd(2'b00, 5, "R2 byte"); rd(2'b01, 6, "R2 word"); rd(2'b10, 12, "R2 dword");

    // R3: little-endian order
    wr(2'b10, 'h40, 64'h0000_0000_1234_5678, "R3 write");
    rd(2'b00, 'h40, "R3 low byte");
    rd(2'b00, 'h43, "R3 high byte");
    rd(2'b01, 'h42, "R3 upper word");
    rd(2'b01, 'h40, "R3 lower word");
    rd(2'b11, 'h40, "R3 quad");

    // R4: narrow writes leave neighbours untouched
    wr(2'b00, 'h41, 64'hFFFF_FFFF_FFFF_FFAA, "R4 byte write");
    rd(2'b11, 'h40, "R4 after byte");
    wr(2'b01, 'h86, 64'hDEAD_BEEF_CAFE_BEEF, "R4 word write");
    rd(2'b11, 'h80, "R4 after word");
    wr(2'b10, 'h94, 64'h1111_2222_3333_4444, "R4 dword write");
    rd(2'b11, 'h90, "R4 after dword");
    rd(2'b11, 'h98, "R4 next row");

    // R5: misaligned writes flagged and dropped
    wr(2'b01, 'h51, 64'hFFFF, "R5 word odd");
    rd(2'b11, 'h50, "R5 row unchanged");
    wr(2'b10, 'h62, 64'hFFFF_FFFF, "R5 dword off2");
    rd(2'b11, 'h60, "R5 row unchanged");
    wr(2'b11, 'h74, 64'hFFFF_FFFF_FFFF_FFFF, "R5 quad off4");
    rd(2'b11, 'h70, "R5 row unchanged");
    rd(2'b11, 'h78, "R5 row unchanged");
    wr(2'b11, 'h7F, 64'd0, "R5 quad off7");
    wr(2'b01, 'h52, 64'h0BAD, "R5 aligned word ok");
    rd(2'b11, 'h50, "R5 aligned applied");

    // R6: misaligned reads
    rd(2'b01, 'h43, "R6 word odd");
    rd(2'b10, 'h41, "R6 dword off1");
    rd(2'b11, 'h42, "R6 quad off2");
    rd(2'b00, 'h43, "R6 byte fine after");

    // R7: zero padding over all-ones data
    wr(2'b11, 'h100, 64'hFFFF_FFFF_FFFF_FFFF, "R7 ones");
    rd(2'b00, 'h107, "R7 byte pad");
    rd(2'b01, 'h104, "R7 word pad");
    rd(2'b10, 'h104, "R7 dword pad");
    rd(2'b11, 'h100, "R7 quad");

    // R8: idle and write cycles give no response
    idle("R8 idle");
    wr(2'b00, 'h200, 64'h77, "R8 write no valid");
    idle("R8 idle");
    rd(2'b00, 'h200, "R8 read valid");
    rd(2'b00, 'h201, "R8 back to back");
    idle("R8 idle after read");

    // R9: top of the address space
    wr(2'b00, NB - 1, 64'h5E, "R9 top byte");
    rd(2'b00, NB - 1, "R9 top byte");
    rd(2'b11, NB - 8, "R9 top quad");
    rd(2'b00, 0, "R9 bottom byte");

    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      int a;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      sz = rng[1:0];
      a  = int'(rng[AW+7:8]);
      if (rng[30:29] != 2'b00) a = a & ~((1 << sz) - 1);
      if (rng[31]) wr(sz, a, {rng, ~rng}, "R4 R5 mixed write");
      else         rd(sz, a, "R3 R7 mixed read");
    end

    idle("drain");
    idle("drain");
    wait (sb.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule